// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a 32-line general-purpose I/O port. Software reaches it over a plain 32-bit register bus made of a word address, a write strobe, write data and read data. Writes take effect on the rising clock edge. Read data is combinational from the address. Each pin has three separate pad signals: a drive value, a drive enable and a sampled input.

Each line can be an input or an output. An output line can be set to open-drain, so that it drives only a low level. Input values pass through a two-flop synchronizer. They reach the data register only when the line's input-buffer bit is set. Every line has an edge detector that watches for either falling edges only or both edges, and stores what it sees in a sticky event register. Software clears an event by writing a one to its bit. A single interrupt output is active while any event is both latched and unmasked.

Line n uses register bit 31-n in every register. The pad vectors are indexed by line number.

Top module: `pio_port`

## Requirements
- R1: After reset every register reads 0 at every offset, the interrupt output is low, and no pad drive enable is active.
- R2: Word offsets are direction 0x00, open-drain 0x04, data 0x08, event 0x0C, mask 0x10, edge control 0x14 and input-buffer enable 0x18. Direction, open-drain, mask, control and input-buffer enable read back the value last written. Offset 0x1C and any address whose two low bits are not zero read 0, and writes to them change nothing.
- R3: Line n (pad vector index n) is controlled by register bit 31-n in every register.
- R4: A direction bit of 1 makes its line an output: the drive enable goes high and the drive value equals the stored data bit. A direction bit of 0 releases the line.
- R5: An output line whose open-drain bit is 1 has its drive enable low while its data bit is 1. While its data bit is 0 it drives 0.
- R6: A data read returns the stored bit for output lines. For input lines it returns the synchronized pad value when the line's input-buffer bit is 1, and 0 otherwise. A pad change becomes visible after the second rising edge.
- R7: A control bit of 1 detects falling edges only. A control bit of 0 detects both edges. The event bit is set at the third rising edge after the pad change, whatever the line's direction or input-buffer setting.
- R8: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. A write never sets an event.
- R9: When a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R10: The interrupt output is high exactly when the bitwise AND of event and mask is non-zero. Events latch while masked, so unmasking a pending event raises the interrupt after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Sampled pad levels, index = line |
| pad_out | output | 32 | Pad drive values, index = line |
| pad_oe | output | 32 | Pad drive enables, index = line |
| irq | output | 1 | Combined interrupt |

## Verification
Edge capture and a software clear of the event register can land on the same rising edge. The bench provokes this by changing a pad and then issuing the clearing write exactly two edges later, so that the write's edge is the one where the synchronized edge reaches the event register. The same write also clears a second, older event. The result is judged by reading the event register back: the new event must remain set while the older one is gone.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned REG_W = 32;

  typedef enum logic [2:0] {
    SEL_DIR  = 3'd0,
    SEL_ODR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_CTL  = 3'd5,
    SEL_IBE  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  // Swaps line order and register bit order; the mapping is its own inverse.
  function automatic logic [REG_W-1:0] lane_flip(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W; i++) r[REG_W-1-i] = v[i];
    return r;
  endfunction

  // Sticky event update: clear by mask, then new hits win.
  function automatic logic [REG_W-1:0] evt_update(input logic [REG_W-1:0] evt,
                                                  input logic [REG_W-1:0] clr,
                                                  input logic [REG_W-1:0] hit);
    return (evt & ~clr) | hit;
  endfunction

  // Data view: stored value on outputs, gated pin value on inputs.
  function automatic logic [REG_W-1:0] data_view(input logic [REG_W-1:0] dat,
                                                 input logic [REG_W-1:0] dir,
                                                 input logic [REG_W-1:0] pin,
                                                 input logic [REG_W-1:0] ibe);
    return (dat & dir) | (pin & ibe & ~dir);
  endfunction
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_evt.sv
module pio_evt
  import pio_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] fall_only,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] evt_q
);
  logic [W-1:0] prev_q;

  for (genvar b = 0; b < W; b++) begin : g_det
    logic rise, fall;
    assign rise        = ~prev_q[b] & level[b];
    assign fall        = prev_q[b] & ~level[b];
    assign edge_hit[b] = fall | (rise & ~fall_only[b]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= level;
      evt_q  <= evt_update(evt_q, clr_mask, edge_hit);
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~edge_hit)) |=> ((evt_q & $past(clr_mask & ~edge_hit)) == '0)); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((evt_q & $past(edge_hit)) == $past(edge_hit))); // R9
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(evt_q & ~clr_mask)) == $past(evt_q & ~clr_mask))); // R10
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & $past(fall_only & level & ~prev_q)) == '0)); // R7
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  pad_in,
  output logic [REG_W-1:0]  pad_out,
  output logic [REG_W-1:0]  pad_oe,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [REG_W-1:0] dir_q, odr_q, dat_q, msk_q, ctl_q, ibe_q;
  logic [REG_W-1:0] pin_sync, evt_q, edge_hit, clr_mask, oe_bits;
  logic [IDX_W-1:0] word_idx;
  reg_sel_e         sel;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign sel = (bus_addr[1:0] == 2'b00 && word_idx < IDX_W'(7))
             ? reg_sel_e'(word_idx[2:0]) : SEL_NONE;

  pio_sync #(.W(REG_W), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(lane_flip(pad_in)), .q(pin_sync));

  assign clr_mask = (bus_we && sel == SEL_EVT) ? bus_wdata : '0;

  pio_evt #(.W(REG_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .level(pin_sync), .fall_only(ctl_q),
    .clr_mask(clr_mask), .edge_hit(edge_hit), .evt_q(evt_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; odr_q <= '0; dat_q <= '0;
      msk_q <= '0; ctl_q <= '0; ibe_q <= '0;
    end else if (bus_we) begin
      case (sel)
        SEL_DIR: dir_q <= bus_wdata;
        SEL_ODR: odr_q <= bus_wdata;
        SEL_DAT: dat_q <= bus_wdata;
        SEL_MSK: msk_q <= bus_wdata;
        SEL_CTL: ctl_q <= bus_wdata;
        SEL_IBE: ibe_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DIR: bus_rdata = dir_q;
      SEL_ODR: bus_rdata = odr_q;
      SEL_DAT: bus_rdata = data_view(dat_q, dir_q, pin_sync, ibe_q);
      SEL_EVT: bus_rdata = evt_q;
      SEL_MSK: bus_rdata = msk_q;
      SEL_CTL: bus_rdata = ctl_q;
      SEL_IBE: bus_rdata = ibe_q;
      default: bus_rdata = '0;
    endcase
  end

  assign oe_bits = dir_q & ~(odr_q & dat_q);
  assign pad_oe  = lane_flip(oe_bits);
  assign pad_out = lane_flip(dat_q);
  assign irq     = |(evt_q & msk_q);

  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_out & lane_flip(odr_q)) == '0)); // R5
  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq); // R10
  AST_IRQ_ON_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_MSK && |(evt_q & bus_wdata)) |=> irq); // R10
  AST_RELEASED_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~lane_flip(dir_q)) == '0)); // R4
endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  pio_port u_pio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  // register table: address, write value, expected read-back (applied in order)
  localparam logic [4:0]  T_ADDR [8] = '{5'h00, 5'h04, 5'h10, 5'h14, 5'h18, 5'h1C, 5'h0C, 5'h08};
  localparam logic [31:0] T_WR   [8] = '{32'hF0F0_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                                         32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] T_EXP  [8] = '{32'hF0F0_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0,
                                         32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000, 32'hF0F0_0001};

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pad_in = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog got=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state at every offset
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4), v);
      chk("R1 read", v, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);

    // R2: table walk
    for (int i = 0; i < 8; i++) begin
      wr(T_ADDR[i], T_WR[i]);
      rd(T_ADDR[i], v);
      chk("R2 table", v, T_EXP[i]);
    end
    wr(5'h01, 32'hFFFF_FFFF);
    rd(5'h00, v);
    chk("R2 misaligned write ignored", v, 32'hF0F0_0001);

    do_reset();
    // R3/R4: line 0 as output drives pad 0 from bit 31
    wr(5'h00, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    chk("R3 R4 pad_oe", pad_oe, 32'h0000_0001);
    chk("R4 pad_out", pad_out, 32'h0000_0001);
    // R5: open-drain releases a high, drives a low
    wr(5'h04, 32'h8000_0000);
    chk("R5 od high released", pad_oe, 32'h0);
    wr(5'h08, 32'h0);
    chk("R5 od low driven", pad_oe, 32'h0000_0001);
    chk("R5 od low value", pad_out, 32'h0);

    // R6: line 5 (bit 26) input, gated by input buffer enable
    pad_in[5] = 1'b1;
    step(3);
    rd(5'h08, v);
    chk("R6 gated off", v, 32'h0);
    rd(5'h0C, v);
    chk("R7 rise with buffer off", v, 32'h0400_0000);
    wr(5'h18, 32'h0400_0000);
    rd(5'h08, v);
    chk("R6 gated on", v, 32'h0400_0000);
    // R8: zero write keeps, one write clears
    wr(5'h0C, 32'h0);
    rd(5'h0C, v);
    chk("R8 zero write", v, 32'h0400_0000);
    wr(5'h0C, 32'h0400_0000);
    rd(5'h0C, v);
    chk("R8 clear", v, 32'h0);

    // R6/R7 timing on a falling edge, both-edge mode
    pad_in[5] = 1'b0;
    step(2);
    rd(5'h08, v);
    chk("R6 two-edge latency", v, 32'h0);
    rd(5'h0C, v);
    chk("R7 not yet", v, 32'h0);
    step(1);
    rd(5'h0C, v);
    chk("R7 third edge", v, 32'h0400_0000);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R7: falling only
    wr(5'h14, 32'h0400_0000);
    pad_in[5] = 1'b1;
    step(4);
    rd(5'h0C, v);
    chk("R7 rise ignored", v, 32'h0);
    pad_in[5] = 1'b0;
    step(4);
    rd(5'h0C, v);
    chk("R7 fall seen", v, 32'h0400_0000);

    // R10: latched while masked, unmask raises irq
    chk("R10 masked", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0400_0000);
    chk("R10 unmask", {31'h0, irq}, 32'h1);
    wr(5'h0C, 32'h0400_0000);
    chk("R10 cleared", {31'h0, irq}, 32'h0);

    // R9: edge and clear in the same cycle
    wr(5'h14, 32'h0);
    pad_in[6] = 1'b1;
    step(4);
    rd(5'h0C, v);
    chk("R7 line 6 event", v, 32'h0200_0000);
    pad_in[5] = 1'b1;
    step(2);
    wr(5'h0C, 32'h0600_0000);
    rd(5'h0C, v);
    chk("R9 edge beats clear", v, 32'h0400_0000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule